// File: doc/BRIEF.md
# SPI Serial Flash Command Front End

This block is the slave-side front end of a small SPI serial flash. It oversamples chip select, serial clock and serial input with a fast system clock, frames the incoming bit stream into an opcode, a 24-bit address and, for the fast read, one dummy byte. Commands that change the device are handed to the status/protection and array logic as a single execute pulse when chip select is released. Reads, identification and status are shifted out MSB first on the serial output.

The array model supplies read bytes through a combinational address/data pair. The status block supplies the current status byte. Page-program data bytes are streamed out one strobe per byte with a page-relative index, followed by one commit pulse. The system clock must run at least four times faster than the serial clock.

Top module: `sflash_cmd_front`

## Requirements
- R1: Serial input is taken on rising serial-clock edges and serial output changes only after falling edges, MSB first; both clock-idle-low (mode 0) and clock-idle-high (mode 3) framing work.
- R2: Each modifying opcode produces exactly one `exec_valid` pulse after chip select rises, with `exec_op` encoded as 1 = 06h write enable, 2 = 04h write disable, 3 = 01h status write, 4 = 20h sector erase, 5 = 52h/D8h block erase, 6 = 60h/C7h chip erase, 7 = 02h page program, 8 = B9h power down, 9 = ABh wake.
- R3: A modifying command is discarded when chip select rises after a partial byte, or before its full length: 2 bytes for status write, 4 for the erases, 5 for page program, 1 for the rest.
- R4: An unrecognised opcode keeps `spi_so_oe` low, produces no execute pulse, and all later input bits are ignored until the next chip-select fall.
- R5: Opcode 9Fh returns the bytes C2h, 22h, 11h and then repeats this sequence while chip select stays low.
- R6: Opcode 05h returns `st_byte` repeatedly, each byte being the value present when that byte is loaded; a change during a byte appears only in the next byte.
- R7: Opcode 03h takes a 3-byte address and streams `rd_data` from `rd_addr`, which starts at the address modulo the memory size and increments after each byte.
- R8: Opcode 0Bh skips one dummy byte after the address, then streams as R7; the address returns to 0 after the top address.
- R9: During page program each complete data byte gives one `pg_we` pulse with `pg_byte`, and `pg_idx` starts at address bits 4:0 and increments modulo 32; the commit is the `exec_valid` pulse with op 7.
- R10: `exec_addr` carries the 24-bit address of erase and program commands, and `exec_data` carries the second byte of a status write.
- R11: After reset `spi_so_oe`, `spi_so`, `exec_valid` and `pg_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low, asynchronous |
| spi_sclk | input | 1 | Serial clock, asynchronous |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable for `spi_so` (low = high-Z) |
| exec_valid | output | 1 | One-cycle execute pulse for an accepted modifying command |
| exec_op | output | 4 | Execute operation code (see R2) |
| exec_addr | output | 24 | Captured address |
| exec_data | output | 8 | Status-write data byte |
| pg_we | output | 1 | Page data byte strobe |
| pg_idx | output | 5 | Byte index within the page |
| pg_byte | output | 8 | Page data byte |
| rd_addr | output | 17 | Read address to the array |
| rd_data | input | 8 | Read data from the array |
| st_byte | input | 8 | Current status byte |

## Verification
The status input and the byte reload of a status read can coincide: the reload on a falling edge takes a snapshot of `st_byte`, so a status change that lands while a byte is in flight must not alter that byte. The bench changes `st_byte` in the middle of the second status byte and expects the old value for that byte and the new one for the third. The other coincidence is the chip-select release arriving right after the final rising edge of a command; the bench releases at byte boundaries and after partial bytes in both clock modes and expects an execute pulse only in the first case.

// File: rtl/sflash_pkg.sv
// Shared types for the serial flash command front end.
package sflash_pkg;

    typedef enum logic [3:0] {
        K_BAD    = 4'd0,
        K_WREN   = 4'd1,
        K_WRDI   = 4'd2,
        K_WRSR   = 4'd3,
        K_SERASE = 4'd4,
        K_BERASE = 4'd5,
        K_CERASE = 4'd6,
        K_PPROG  = 4'd7,
        K_PDOWN  = 4'd8,
        K_WAKE   = 4'd9,
        K_RDID   = 4'd10,
        K_RDSR   = 4'd11,
        K_READ   = 4'd12,
        K_FREAD  = 4'd13
    } cmd_kind_e;

    // Minimum number of whole bytes a modifying command needs.
    function automatic logic [2:0] min_len(cmd_kind_e k);
        case (k)
            K_WRSR:                     return 3'd2;
            K_SERASE, K_BERASE:         return 3'd4;
            K_PPROG:                    return 3'd5;
            default:                    return 3'd1;
        endcase
    endfunction

    // True for commands that are executed at chip-select release.
    function automatic logic is_modify(cmd_kind_e k);
        return (k >= K_WREN) && (k <= K_WAKE);
    endfunction

endpackage

// File: rtl/sflash_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes STAGES >= 2; each bit is synchronized independently.
module sflash_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    // Shift the inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/sflash_opdec.sv
// Opcode decoder: maps a received opcode byte onto a command kind.
// Any code outside the command set decodes to K_BAD.
module sflash_opdec
    import sflash_pkg::*;
(
    input  logic [7:0] op_byte,
    output cmd_kind_e  kind
);
    // Combinational opcode lookup.
    always_comb begin
        case (op_byte)
            8'h06:        kind = K_WREN;
            8'h04:        kind = K_WRDI;
            8'h01:        kind = K_WRSR;
            8'h20:        kind = K_SERASE;
            8'h52, 8'hD8: kind = K_BERASE;
            8'h60, 8'hC7: kind = K_CERASE;
            8'h02:        kind = K_PPROG;
            8'hB9:        kind = K_PDOWN;
            8'hAB:        kind = K_WAKE;
            8'h9F:        kind = K_RDID;
            8'h05:        kind = K_RDSR;
            8'h03:        kind = K_READ;
            8'h0B:        kind = K_FREAD;
            default:      kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/sflash_tx.sv
// Output shifter: loads a byte, presents its MSB, shifts left on request.
// The output enable rises on the first load and clears with clr.
module sflash_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       load,
    input  logic [7:0] din,
    input  logic       shift,
    output logic       so,
    output logic       oe
);
    logic [7:0] sh;

    // Load, shift or clear the output byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sh <= '0;
            oe <= 1'b0;
        end else if (load) begin
            sh <= din;
            oe <= 1'b1;
        end else if (shift && oe) begin
            sh <= {sh[6:0], 1'b0};
        end
    end

    assign so = oe & sh[7];
endmodule

// File: rtl/sflash_cmd_front.sv
// Serial flash command front end. Oversamples the SPI pins, frames
// opcode/address/dummy/data bytes, issues execute and page strobes and
// shifts read, ID and status bytes out. Assumes clk >= 4x serial clock,
// MEM_BYTES and PAGE_BYTES powers of two, PAGE_BYTES <= 256.
module sflash_cmd_front
    import sflash_pkg::*;
#(
    parameter int         MEM_BYTES   = 131072,
    parameter int         PAGE_BYTES  = 32,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] MFR_ID      = 8'hC2,
    parameter logic [7:0] TYPE_ID     = 8'h22,
    parameter logic [7:0] DENS_ID     = 8'h11
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            spi_cs_n,
    input  logic                            spi_sclk,
    input  logic                            spi_si,
    output logic                            spi_so,
    output logic                            spi_so_oe,
    output logic                            exec_valid,
    output logic [3:0]                      exec_op,
    output logic [23:0]                     exec_addr,
    output logic [7:0]                      exec_data,
    output logic                            pg_we,
    output logic [$clog2(PAGE_BYTES)-1:0]   pg_idx,
    output logic [7:0]                      pg_byte,
    output logic [$clog2(MEM_BYTES)-1:0]    rd_addr,
    input  logic [7:0]                      rd_data,
    input  logic [7:0]                      st_byte
);
    localparam int AW = $clog2(MEM_BYTES);
    localparam int PW = $clog2(PAGE_BYTES);

    logic [2:0]    sync_q;
    logic          cs_s, sclk_s, si_s, cs_d, sclk_d;
    logic          cs_fall, cs_rise, sck_rise, sck_fall;
    logic [2:0]    bit_cnt, nbytes;
    logic [6:0]    sh_in;
    logic [7:0]    byte_in;
    logic          byte_done, ign_q, live;
    cmd_kind_e     kind_q, kind_now;
    logic [23:0]   addr_q, addr_nx;
    logic [7:0]    wsr_q;
    logic [PW-1:0] wptr;
    logic [1:0]    id_sel;
    logic          tx_load, tx_shift, rd_load;
    logic [7:0]    tx_din, id_byte;

    sflash_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({spi_si, spi_sclk, spi_cs_n}), .q(sync_q)
    );
    assign cs_s   = sync_q[0];
    assign sclk_s = sync_q[1];
    assign si_s   = sync_q[2];

    // Delay synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d   <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            cs_d   <= cs_s;
            sclk_d <= sclk_s;
        end
    end

    assign cs_fall   = cs_d & ~cs_s;
    assign cs_rise   = ~cs_d & cs_s;
    assign sck_rise  = ~sclk_d & sclk_s & ~cs_s;
    assign sck_fall  = sclk_d & ~sclk_s & ~cs_s;
    assign live      = ~ign_q;
    assign byte_in   = {sh_in, si_s};
    assign byte_done = sck_rise & live & (bit_cnt == 3'd7);
    assign addr_nx   = {addr_q[15:0], byte_in};

    sflash_opdec u_dec (.op_byte(byte_in), .kind(kind_now));

    // Bit and byte framing, opcode capture and the ignore state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            nbytes  <= '0;
            sh_in   <= '0;
            ign_q   <= 1'b0;
            kind_q  <= K_BAD;
        end else if (cs_fall) begin
            bit_cnt <= '0;
            nbytes  <= '0;
            ign_q   <= 1'b0;
        end else if (sck_rise && live) begin
            bit_cnt <= bit_cnt + 3'd1;
            sh_in   <= byte_in[6:0];
            if (bit_cnt == 3'd7) begin
                if (nbytes != 3'd7) nbytes <= nbytes + 3'd1;
                if (nbytes == 3'd0) begin
                    kind_q <= kind_now;
                    ign_q  <= (kind_now == K_BAD);
                end
            end
        end
    end

    // Address, status-write byte and page pointer capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            wsr_q  <= '0;
            wptr   <= '0;
        end else if (byte_done) begin
            if (nbytes >= 3'd1 && nbytes <= 3'd3) addr_q <= addr_nx;
            if (nbytes == 3'd1) wsr_q <= byte_in;
            if (nbytes == 3'd3) wptr <= byte_in[PW-1:0];
            else if (kind_q == K_PPROG && nbytes >= 3'd4) wptr <= wptr + 1'b1;
        end
    end

    // Page data strobes, one per complete data byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pg_we   <= 1'b0;
            pg_idx  <= '0;
            pg_byte <= '0;
        end else begin
            pg_we <= byte_done && (kind_q == K_PPROG) && (nbytes >= 3'd4);
            if (byte_done) begin
                pg_idx  <= wptr;
                pg_byte <= byte_in;
            end
        end
    end

    // Choose the next output byte and whether to load it on this fall.
    always_comb begin
        id_byte = (id_sel == 2'd0) ? MFR_ID : (id_sel == 2'd1) ? TYPE_ID : DENS_ID;
        tx_din  = 8'h00;
        tx_load = 1'b0;
        rd_load = 1'b0;
        if (sck_fall && live && bit_cnt == 3'd0 && nbytes != 3'd0) begin
            case (kind_q)
                K_RDID:  begin tx_load = 1'b1; tx_din = id_byte; end
                K_RDSR:  begin tx_load = 1'b1; tx_din = st_byte; end
                K_READ:  begin rd_load = (nbytes >= 3'd4); tx_load = rd_load; tx_din = rd_data; end
                K_FREAD: begin rd_load = (nbytes >= 3'd5); tx_load = rd_load; tx_din = rd_data; end
                default: ;
            endcase
        end
        tx_shift = sck_fall && live && (bit_cnt != 3'd0);
    end

    // Read pointer and ID byte sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_addr <= '0;
            id_sel  <= '0;
        end else begin
            if (cs_fall) id_sel <= '0;
            else if (tx_load && kind_q == K_RDID) id_sel <= (id_sel == 2'd2) ? 2'd0 : id_sel + 2'd1;
            if (byte_done && nbytes == 3'd3) rd_addr <= addr_nx[AW-1:0];
            else if (rd_load) rd_addr <= rd_addr + 1'b1;
        end
    end

    // Execute decision at chip-select release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exec_valid <= 1'b0;
            exec_op    <= '0;
            exec_addr  <= '0;
            exec_data  <= '0;
        end else begin
            exec_valid <= 1'b0;
            if (cs_rise && live && bit_cnt == 3'd0 && is_modify(kind_q)
                && nbytes >= min_len(kind_q)) begin
                exec_valid <= 1'b1;
                exec_op    <= kind_q;
                exec_addr  <= addr_q;
                exec_data  <= wsr_q;
            end
        end
    end

    sflash_tx u_tx (
        .clk(clk), .rst_n(rst_n), .clr(cs_s), .load(tx_load), .din(tx_din),
        .shift(tx_shift), .so(spi_so), .oe(spi_so_oe)
    );
endmodule

// File: rtl/sflash_cmd_front_chk.sv
// Assertion checker for sflash_cmd_front, attached by bind.
module sflash_cmd_front_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       spi_cs_n,
    input logic       spi_so_oe,
    input logic       exec_valid,
    input logic [3:0] exec_op,
    input logic       pg_we,
    input logic       ign_q
);
    AST_EXEC_ONE_CYCLE:   assert property (@(posedge clk) disable iff (!rst_n) exec_valid |=> !exec_valid); // R2
    AST_EXEC_OP_LEGAL:    assert property (@(posedge clk) disable iff (!rst_n) exec_valid |-> (exec_op >= 4'd1 && exec_op <= 4'd9)); // R2
    AST_EXEC_DESELECTED:  assert property (@(posedge clk) disable iff (!rst_n) exec_valid |-> spi_cs_n); // R3
    AST_IGNORE_QUIET:     assert property (@(posedge clk) disable iff (!rst_n) ign_q |-> !spi_so_oe); // R4
    AST_PG_ONE_CYCLE:     assert property (@(posedge clk) disable iff (!rst_n) pg_we |=> !pg_we); // R9
    AST_PG_NOT_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n) !(pg_we && exec_valid)); // R9
    AST_OE_WHILE_SEL:     assert property (@(posedge clk) disable iff (!rst_n) $rose(spi_so_oe) |-> !spi_cs_n); // R1
endmodule

bind sflash_cmd_front sflash_cmd_front_chk u_chk (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_so_oe(spi_so_oe),
    .exec_valid(exec_valid), .exec_op(exec_op), .pg_we(pg_we), .ign_q(ign_q)
);

// File: tb/sflash_cmd_front_tb.sv
`timescale 1ns/1ps
module sflash_cmd_front_tb_top;
    localparam int HP = 8;  // serial half period in system clocks

    logic        clk = 1'b0;
    logic        rst_n, cs_n, sclk, si;
    logic        so, so_oe, exec_valid, pg_we;
    logic [3:0]  exec_op;
    logic [23:0] exec_addr;
    logic [7:0]  exec_data, pg_byte, rd_data, st_byte;
    logic [4:0]  pg_idx;
    logic [16:0] rd_addr;

    int  n_chk = 0, n_fail = 0;
    bit  mode3 = 1'b0, done = 1'b0, last_oe;
    logic [7:0]  txq[$];
    logic [37:0] exp_exec[$];  // {op, addr, data, chk_addr, chk_data}
    logic [12:0] exp_pg[$];    // {idx, byte}

    always #4 clk = ~clk;

    function automatic logic [7:0] mem_f(input logic [16:0] a);
        return a[7:0] ^ a[15:8] ^ {7'd0, a[16]} ^ 8'h3C;
    endfunction
    assign rd_data = mem_f(rd_addr);

    sflash_cmd_front dut_i (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_si(si),
        .spi_so(so), .spi_so_oe(so_oe), .exec_valid(exec_valid), .exec_op(exec_op),
        .exec_addr(exec_addr), .exec_data(exec_data), .pg_we(pg_we), .pg_idx(pg_idx),
        .pg_byte(pg_byte), .rd_addr(rd_addr), .rd_data(rd_data), .st_byte(st_byte)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pop expected execute and page items as the design emits them.
    always @(negedge clk) begin
        if (rst_n && exec_valid) begin
            if (exp_exec.size() == 0) chk("R3 unexpected exec", {exec_op, exec_addr}, 0);
            else begin
                logic [37:0] e;
                e = exp_exec.pop_front();
                chk("R2 exec_op", exec_op, e[37:34]);
                if (e[1]) chk("R10 exec_addr", exec_addr, e[33:10]);
                if (e[0]) chk("R10 exec_data", exec_data, e[9:2]);
            end
        end
        if (rst_n && pg_we) begin
            if (exp_pg.size() == 0) chk("R9 unexpected pg_we", {pg_idx, pg_byte}, 0);
            else chk("R9 page byte", {pg_idx, pg_byte}, exp_pg.pop_front());
        end
    end

    task automatic wait_half();
        repeat (HP) @(negedge clk);
    endtask

    task automatic cs_lo(input bit m3);
        mode3 = m3;
        sclk  = m3;
        repeat (4) @(negedge clk);
        cs_n = 1'b0;
        wait_half();
    endtask

    task automatic cs_hi();
        wait_half();
        cs_n = 1'b1;
        repeat (3 * HP) @(negedge clk);
    endtask

    // Clock nb bits of tx out, collect nb bits from so; optional status change.
    task automatic xbits(input logic [7:0] tx, input int nb, output logic [7:0] rx,
                         output bit oe_any, input int chg_bit, input logic [7:0] chg_val);
        rx = '0;
        oe_any = 1'b0;
        for (int i = 0; i < nb; i++) begin
            if (mode3) sclk = 1'b0;
            si = tx[7-i];
            wait_half();
            rx = {rx[6:0], so};
            oe_any |= so_oe;
            if (i == chg_bit) st_byte = chg_val;
            sclk = 1'b1;
            wait_half();
            if (!mode3) sclk = 1'b0;
        end
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        bit oe;
        xbits(tx, 8, rx, oe, -1, 8'h00);
    endtask

    // Send txq as whole bytes plus tail_bits of a partial byte.
    task automatic frame(input bit m3, input int tail_bits);
        logic [7:0] rx;
        bit oe;
        last_oe = 1'b0;
        cs_lo(m3);
        foreach (txq[i]) begin
            xbits(txq[i], 8, rx, oe, -1, 8'h00);
            last_oe |= oe;
        end
        if (tail_bits > 0) begin
            xbits(8'hA5, tail_bits, rx, oe, -1, 8'h00);
            last_oe |= oe;
        end
        cs_hi();
    endtask

    task automatic push_exec(input logic [3:0] op, input logic [23:0] a, input logic [7:0] d,
                             input bit ca, input bit cd);
        exp_exec.push_back({op, a, d, ca, cd});
    endtask

    task automatic settle(input string req);
        chk({req, " pending exec"}, exp_exec.size(), 0);
        chk({req, " pending page"}, exp_pg.size(), 0);
    endtask

    task automatic rd_cmd(input bit m3, input logic [7:0] op, input logic [23:0] a,
                          input int n, input bit dummy, input string req);
        logic [7:0]  rx;
        logic [16:0] ptr;
        cs_lo(m3);
        xbyte(op, rx); xbyte(a[23:16], rx); xbyte(a[15:8], rx); xbyte(a[7:0], rx);
        if (dummy) xbyte(8'h00, rx);
        ptr = a[16:0];
        for (int k = 0; k < n; k++) begin
            xbyte(8'h00, rx);
            chk(req, rx, mem_f(ptr));
            ptr = ptr + 17'd1;
        end
        cs_hi();
    endtask

    task automatic id_cmd(input bit m3, input string req);
        logic [7:0] rx;
        logic [7:0] ids [4] = '{8'hC2, 8'h22, 8'h11, 8'hC2};
        cs_lo(m3);
        xbyte(8'h9F, rx);
        for (int k = 0; k < 4; k++) begin
            xbyte(8'h00, rx);
            chk(req, rx, ids[k]);
        end
        cs_hi();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx;
        bit oe;
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; si = 1'b0; st_byte = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R11 so_oe", so_oe, 0);
        chk("R11 so", so, 0);
        chk("R11 exec_valid", exec_valid, 0);
        chk("R11 pg_we", pg_we, 0);

        // R2: single-byte modifying commands in both modes
        txq.delete(); txq.push_back(8'h06); push_exec(4'd1, 0, 0, 0, 0); frame(0, 0);
        txq.delete(); txq.push_back(8'h04); push_exec(4'd2, 0, 0, 0, 0); frame(1, 0);
        txq.delete(); txq.push_back(8'h60); push_exec(4'd6, 0, 0, 0, 0); frame(0, 0);
        txq.delete(); txq.push_back(8'hC7); push_exec(4'd6, 0, 0, 0, 0); frame(1, 0);
        txq.delete(); txq.push_back(8'hB9); push_exec(4'd8, 0, 0, 0, 0); frame(0, 0);
        txq.delete(); txq.push_back(8'hAB); push_exec(4'd9, 0, 0, 0, 0); frame(1, 0);
        settle("R2");

        // R10: status write data and erase addresses
        txq.delete(); txq.push_back(8'h01); txq.push_back(8'h9C);
        push_exec(4'd3, 0, 8'h9C, 0, 1); frame(0, 0);
        txq.delete(); txq.push_back(8'h20); txq.push_back(8'h01); txq.push_back(8'h23); txq.push_back(8'h45);
        push_exec(4'd4, 24'h012345, 0, 1, 0); frame(1, 0);
        txq.delete(); txq.push_back(8'hD8); txq.push_back(8'h00); txq.push_back(8'h80); txq.push_back(8'h00);
        push_exec(4'd5, 24'h008000, 0, 1, 0); frame(0, 0);
        txq.delete(); txq.push_back(8'h52); txq.push_back(8'h01); txq.push_back(8'h00); txq.push_back(8'h07);
        push_exec(4'd5, 24'h010007, 0, 1, 0); frame(1, 0);
        settle("R10");

        // R3: partial trailing bits and short commands are discarded
        txq.delete(); txq.push_back(8'h06); frame(0, 3);
        txq.delete(); txq.push_back(8'h01); txq.push_back(8'h55); frame(1, 5);
        txq.delete(); txq.push_back(8'h01); frame(0, 0);
        txq.delete(); txq.push_back(8'h20); txq.push_back(8'h01); txq.push_back(8'h23); frame(1, 0);
        settle("R3");

        // R4: unknown opcode ignores the rest, including a read opcode
        txq.delete(); txq.push_back(8'hFF); txq.push_back(8'h06); txq.push_back(8'h05); txq.push_back(8'h00);
        frame(0, 0);
        chk("R4 so_oe stays low", last_oe, 0);
        txq.delete(); txq.push_back(8'h00); txq.push_back(8'h9F); txq.push_back(8'h00); frame(1, 0);
        chk("R4 so_oe stays low mode3", last_oe, 0);
        settle("R4");
        txq.delete(); txq.push_back(8'h06); push_exec(4'd1, 0, 0, 0, 0); frame(0, 0);
        settle("R4 recovery");

        // R5/R1: identification in both modes
        id_cmd(0, "R5 R1 id mode0");
        id_cmd(1, "R5 R1 id mode3");

        // R6: status snapshot per byte, change lands mid-byte
        st_byte = 8'hA5;
        cs_lo(0);
        xbyte(8'h05, rx);
        xbyte(8'h00, rx); chk("R6 status byte1", rx, 8'hA5);
        xbits(8'h00, 8, rx, oe, 3, 8'h3C); chk("R6 status byte2 snapshot", rx, 8'hA5);
        xbyte(8'h00, rx); chk("R6 status byte3 new", rx, 8'h3C);
        cs_hi();

        // R7: plain read, also with high address bits beyond the array
        rd_cmd(0, 8'h03, 24'h000100, 3, 0, "R7 read mode0");
        rd_cmd(1, 8'h03, 24'hFE0010, 2, 0, "R7 read masked mode3");

        // R8: fast read with dummy byte, wrapping past the top
        rd_cmd(1, 8'h0B, 24'h01FFFE, 4, 1, "R8 fast read wrap");
        rd_cmd(0, 8'h0B, 24'h000042, 2, 1, "R8 fast read mode0");

        // R9: page program wrapping inside the page, then commit
        exp_pg.push_back({5'h1E, 8'h11}); exp_pg.push_back({5'h1F, 8'h22});
        exp_pg.push_back({5'h00, 8'h33}); exp_pg.push_back({5'h01, 8'h44});
        push_exec(4'd7, 24'h00001E, 0, 1, 0);
        txq.delete(); txq.push_back(8'h02); txq.push_back(8'h00); txq.push_back(8'h00); txq.push_back(8'h1E);
        txq.push_back(8'h11); txq.push_back(8'h22); txq.push_back(8'h33); txq.push_back(8'h44);
        frame(0, 0);
        settle("R9");
        // R9/R3: page data strobed but no commit after a partial byte
        exp_pg.push_back({5'h05, 8'hAA});
        txq.delete(); txq.push_back(8'h02); txq.push_back(8'h00); txq.push_back(8'h10); txq.push_back(8'h05);
        txq.push_back(8'hAA);
        frame(1, 4);
        settle("R9 R3 partial");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule